// File: doc/BRIEF.md
# Quadword Atomic Bit-Set Execution Unit

This block executes one instruction: a 128-bit atomic read-modify-write that ORs a value taken from a pair of 64-bit registers into a quadword in memory. It takes a 32-bit instruction word on `start` and decodes the register fields. It reads the two source registers and the base register through a combinational register-file read port, or takes the stack pointer as the base. It then runs a two-step sequence on a valid/ready memory port. The first step is a locked read. The second step is either a write of the OR result or a release of the lock without a write. Which one is chosen depends on the check-pass bit returned with the read data.

When the sequence ends, the unit raises a one-cycle `done`. In that same cycle it writes the old memory contents back to the register pair and loads the four condition flags from the status that came with the read response. Illegal encodings produce an undefined outcome. A repeated destination register produces one of three configured outcomes. A misaligned stack-pointer base produces an alignment fault. Each of these also ends with `done`, and none of them touches the register file or the flags.

Top module: `qw_orset_unit`

## Requirements
- R1: Instruction bit 23 drives `mem_req_acq` and bit 22 drives `mem_req_rel` on every memory request. The first register is bits 4:0, the second is bits 20:16 and the base is bits 9:5. `mem_req_tagchk` is 1 unless the base field is 31.
- R2: If `feat_en` is 0, or any fixed opcode bit differs, the outcome is undefined with no memory request. The fixed bits are 31:24 = 8'h19, bit 21 = 1 and 15:10 = 6'b101100.
- R3: A first or second register field equal to 31 gives the undefined outcome with no memory request.
- R4: When the two register fields are equal, `ovl_mode` selects the outcome. 0 runs normally but returns zero in both halves. 2 gives a no-op, which is `done` with `nop` and no access. 1 and 3 give undefined.
- R5: A base field of 31 takes the address from `sp`. The address must then have its low 4 bits zero, or the outcome is `align_fault` with no memory request. Any other base field takes the address from that register.
- R6: The 128-bit operand is {first, second} when `big_endian` is 1, and {second, first} when it is 0.
- R7: Request op codes are 0 = locked read, 1 = write and 2 = unlock. After the read, a set pass bit gives a write of read data OR operand. A clear pass bit gives an unlock, and memory is left unchanged.
- R8: `rf_wa1`/`rf_wa2` carry the first/second register numbers. When `big_endian` is 1, `rf_wd1` gets old bits 127:64 and `rf_wd2` gets bits 63:0. When it is 0, the halves are swapped.
- R9: `flags` equals the 4-bit status returned with the read response.
- R10: `done` lasts one cycle. `rf_we` and `flags_we` rise only together with `done`, and only for executed outcomes. At most one of `undef`, `nop` and `align_fault` is set, and only with `done`.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request and all its fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feat_en | input | 1 | Feature enable; 0 makes every instruction undefined |
| big_endian | input | 1 | Half ordering of the operand and of the returned data |
| ovl_mode | input | 2 | Outcome when both register fields are equal |
| start | input | 1 | Accept `instr` when not busy |
| instr | input | 32 | Instruction word |
| busy | output | 1 | An instruction is in progress |
| rf_ra1 | output | 5 | Read index, first register |
| rf_ra2 | output | 5 | Read index, second register |
| rf_rab | output | 5 | Read index, base register |
| rf_rd1 | input | 64 | Data, first register |
| rf_rd2 | input | 64 | Data, second register |
| rf_rdb | input | 64 | Data, base register |
| sp | input | 64 | Stack pointer value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_op | output | 2 | 0 locked read, 1 write, 2 unlock |
| mem_req_addr | output | 64 | Quadword address |
| mem_req_wdata | output | 128 | Write data |
| mem_req_acq | output | 1 | Acquire attribute |
| mem_req_rel | output | 1 | Release attribute |
| mem_req_tagchk | output | 1 | Tag check enable |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_rdata | input | 128 | Read data |
| mem_rsp_pass | input | 1 | Check passed, write allowed |
| mem_rsp_nzcv | input | 4 | Status for the flags |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Undefined outcome (with done) |
| nop | output | 1 | No-op outcome (with done) |
| align_fault | output | 1 | Alignment fault outcome (with done) |
| rf_we | output | 1 | Write both result registers |
| rf_wa1 | output | 5 | Write index, first register |
| rf_wa2 | output | 5 | Write index, second register |
| rf_wd1 | output | 64 | Write data, first register |
| rf_wd2 | output | 64 | Write data, second register |
| flags_we | output | 1 | Load the flags |
| flags | output | 4 | N, Z, C, V |

## Verification
A vector table covers all four acquire/release combinations. It crosses them with both endian settings, with both pass and fail check results, and with register-based and stack-pointer bases. Ordering errors and swapped halves therefore give different memory words and register write data, and write-versus-unlock is told apart by the final memory word and the count of each request type. Each illegal pattern is applied once: a reserved register field in either slot, each overlap mode, the feature enable turned off, a wrong opcode bit and a misaligned stack pointer. Each one must end with its own outcome flag and with no memory traffic at all. A run with a stalling ready input shows that the request holds and that the result is unchanged.

// File: rtl/qos_pkg.sv
// Shared types for the quadword atomic bit-set unit.
// Assumes: the memory op encoding is seen by the outside world.
package qos_pkg;
    typedef enum logic [1:0] {
        OP_LRD    = 2'd0,
        OP_WRITE  = 2'd1,
        OP_UNLOCK = 2'd2
    } mem_op_e;

    typedef enum logic [1:0] {
        K_EXEC     = 2'd0,
        K_EXEC_UNK = 2'd1,
        K_UNDEF    = 2'd2,
        K_NOP      = 2'd3
    } kind_e;
endpackage

// File: rtl/qos_decode.sv
// Field decode and legality classification of the instruction word.
// Assumes: instr is held stable by the caller for the whole operation.
module qos_decode
    import qos_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        feat_en,
    input  logic [1:0]  ovl_mode,
    output logic [4:0]  rt,
    output logic [4:0]  rt2,
    output logic [4:0]  rn,
    output logic        acq,
    output logic        rel,
    output logic        use_sp,
    output logic        tagchk,
    output kind_e       kind
);
    localparam logic [7:0] TOP_BITS = 8'h19;
    localparam logic [5:0] MID_BITS = 6'b101100;
    localparam logic [4:0] REG_ZR   = 5'd31;

    logic opc_ok;

    // Split fields and classify the outcome.
    always_comb begin
        rt     = instr[4:0];
        rt2    = instr[20:16];
        rn     = instr[9:5];
        acq    = instr[23];
        rel    = instr[22];
        use_sp = (rn == REG_ZR);
        tagchk = !use_sp;
        opc_ok = (instr[31:24] == TOP_BITS) && instr[21] && (instr[15:10] == MID_BITS);
        if (!feat_en || !opc_ok || rt == REG_ZR || rt2 == REG_ZR) begin
            kind = K_UNDEF;
        end else if (rt == rt2) begin
            case (ovl_mode)
                2'd0:    kind = K_EXEC_UNK;
                2'd2:    kind = K_NOP;
                default: kind = K_UNDEF;
            endcase
        end else begin
            kind = K_EXEC;
        end
    end
endmodule

// File: rtl/qos_pair.sv
// Endian-dependent ordering of two register halves into a double-width
// value, and the matching split of a double-width value into halves.
// Assumes: the same order flag applies to both directions.
module qos_pair #(
    parameter int W = 64
) (
    input  logic           be,
    input  logic [W-1:0]   x1,
    input  logic [W-1:0]   x2,
    input  logic [2*W-1:0] q,
    output logic [2*W-1:0] packed_o,
    output logic [W-1:0]   y1,
    output logic [W-1:0]   y2
);
    // Order the halves by the endian flag.
    always_comb begin
        packed_o = be ? {x1, x2} : {x2, x1};
        y1       = be ? q[2*W-1:W] : q[W-1:0];
        y2       = be ? q[W-1:0]   : q[2*W-1:W];
    end
endmodule

// File: rtl/qos_seq.sv
// Sequencer: decides the outcome, runs locked read then write or unlock,
// and produces the completion pulse with register and flag write enables.
// Assumes: at most one memory request is outstanding; a response arrives
// only after its request was accepted.
module qos_seq
    import qos_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int ALIGN_LG2 = 4,
    localparam int QW       = 2 * XLEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  kind_e            kind,
    input  logic             use_sp,
    input  logic             acq,
    input  logic             rel,
    input  logic             tagchk,
    input  logic [XLEN-1:0]  sp,
    input  logic [XLEN-1:0]  base,
    input  logic [QW-1:0]    operand,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [1:0]       mem_req_op,
    output logic [XLEN-1:0]  mem_req_addr,
    output logic [QW-1:0]    mem_req_wdata,
    output logic             mem_req_acq,
    output logic             mem_req_rel,
    output logic             mem_req_tagchk,
    input  logic             mem_rsp_valid,
    input  logic [QW-1:0]    mem_rsp_rdata,
    input  logic             mem_rsp_pass,
    input  logic [3:0]       mem_rsp_nzcv,
    output logic             done,
    output logic             undef,
    output logic             nop,
    output logic             align_fault,
    output logic             res_we,
    output logic [QW-1:0]    ret_data,
    output logic [3:0]       nzcv
);
    typedef enum logic [2:0] {S_IDLE, S_DECIDE, S_RDREQ, S_RDWAIT, S_WRREQ, S_WRWAIT} st_e;

    st_e             st;
    logic [XLEN-1:0] addr_q;
    logic [QW-1:0]   opnd_q, rdata_q;
    logic            pass_q, unk_q, acq_q, rel_q, tag_q;
    logic            misalign;

    assign misalign = use_sp && (sp[ALIGN_LG2-1:0] != '0);

    // State, captured operands and the one-cycle outcome registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
            addr_q <= '0; opnd_q <= '0; rdata_q <= '0; nzcv <= '0;
            pass_q <= 1'b0; unk_q <= 1'b0; acq_q <= 1'b0; rel_q <= 1'b0; tag_q <= 1'b0;
            done <= 1'b0; undef <= 1'b0; nop <= 1'b0; align_fault <= 1'b0; res_we <= 1'b0;
        end else begin
            done <= 1'b0; undef <= 1'b0; nop <= 1'b0; align_fault <= 1'b0; res_we <= 1'b0;
            case (st)
                S_IDLE: if (start) st <= S_DECIDE;
                S_DECIDE: begin
                    if (kind == K_UNDEF) begin
                        done <= 1'b1; undef <= 1'b1; st <= S_IDLE;
                    end else if (kind == K_NOP) begin
                        done <= 1'b1; nop <= 1'b1; st <= S_IDLE;
                    end else if (misalign) begin
                        done <= 1'b1; align_fault <= 1'b1; st <= S_IDLE;
                    end else begin
                        addr_q <= use_sp ? sp : base;
                        opnd_q <= operand;
                        unk_q  <= (kind == K_EXEC_UNK);
                        acq_q  <= acq; rel_q <= rel; tag_q <= tagchk;
                        st     <= S_RDREQ;
                    end
                end
                S_RDREQ: if (mem_req_ready) st <= S_RDWAIT;
                S_RDWAIT: if (mem_rsp_valid) begin
                    rdata_q <= mem_rsp_rdata;
                    pass_q  <= mem_rsp_pass;
                    nzcv    <= mem_rsp_nzcv;
                    st      <= S_WRREQ;
                end
                S_WRREQ: if (mem_req_ready) st <= S_WRWAIT;
                S_WRWAIT: if (mem_rsp_valid) begin
                    done <= 1'b1; res_we <= 1'b1; st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Memory request fields follow the state.
    always_comb begin
        busy           = (st != S_IDLE);
        mem_req_valid  = (st == S_RDREQ) || (st == S_WRREQ);
        mem_req_op     = (st == S_WRREQ) ? (pass_q ? OP_WRITE : OP_UNLOCK) : OP_LRD;
        mem_req_addr   = addr_q;
        mem_req_wdata  = rdata_q | opnd_q;
        mem_req_acq    = acq_q;
        mem_req_rel    = rel_q;
        mem_req_tagchk = tag_q;
        ret_data       = unk_q ? '0 : rdata_q;
    end
endmodule

// File: rtl/qw_orset_unit.sv
// Top of the quadword atomic bit-set unit: instruction register, decode,
// base selection, operand ordering and the memory sequencer.
// Assumes: register-file reads are combinational from the rf_ra* indices;
// big_endian and ovl_mode are static while an instruction runs.
module qw_orset_unit
    import qos_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int ALIGN_LG2 = 4,
    localparam int QW       = 2 * XLEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            feat_en,
    input  logic            big_endian,
    input  logic [1:0]      ovl_mode,
    input  logic            start,
    input  logic [31:0]     instr,
    output logic            busy,
    output logic [4:0]      rf_ra1,
    output logic [4:0]      rf_ra2,
    output logic [4:0]      rf_rab,
    input  logic [XLEN-1:0] rf_rd1,
    input  logic [XLEN-1:0] rf_rd2,
    input  logic [XLEN-1:0] rf_rdb,
    input  logic [XLEN-1:0] sp,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [1:0]      mem_req_op,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [QW-1:0]   mem_req_wdata,
    output logic            mem_req_acq,
    output logic            mem_req_rel,
    output logic            mem_req_tagchk,
    input  logic            mem_rsp_valid,
    input  logic [QW-1:0]   mem_rsp_rdata,
    input  logic            mem_rsp_pass,
    input  logic [3:0]      mem_rsp_nzcv,
    output logic            done,
    output logic            undef,
    output logic            nop,
    output logic            align_fault,
    output logic            rf_we,
    output logic [4:0]      rf_wa1,
    output logic [4:0]      rf_wa2,
    output logic [XLEN-1:0] rf_wd1,
    output logic [XLEN-1:0] rf_wd2,
    output logic            flags_we,
    output logic [3:0]      flags
);
    logic [31:0]   instr_q;
    logic [4:0]    rt, rt2, rn;
    logic          acq, rel, use_sp, tagchk, res_we;
    kind_e         kind;
    logic [QW-1:0] operand, ret_data;

    // Hold the instruction word for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n)              instr_q <= '0;
        else if (start && !busy) instr_q <= instr;
    end

    qos_decode u_dec (
        .instr(instr_q), .feat_en(feat_en), .ovl_mode(ovl_mode),
        .rt(rt), .rt2(rt2), .rn(rn), .acq(acq), .rel(rel),
        .use_sp(use_sp), .tagchk(tagchk), .kind(kind)
    );

    qos_pair #(.W(XLEN)) u_pair (
        .be(big_endian), .x1(rf_rd1), .x2(rf_rd2), .q(ret_data),
        .packed_o(operand), .y1(rf_wd1), .y2(rf_wd2)
    );

    qos_seq #(.XLEN(XLEN), .ALIGN_LG2(ALIGN_LG2)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
        .use_sp(use_sp), .acq(acq), .rel(rel), .tagchk(tagchk),
        .sp(sp), .base(rf_rdb), .operand(operand), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_acq(mem_req_acq),
        .mem_req_rel(mem_req_rel), .mem_req_tagchk(mem_req_tagchk),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .mem_rsp_pass(mem_rsp_pass), .mem_rsp_nzcv(mem_rsp_nzcv),
        .done(done), .undef(undef), .nop(nop), .align_fault(align_fault),
        .res_we(res_we), .ret_data(ret_data), .nzcv(flags)
    );

    // Register-file indices and write controls.
    always_comb begin
        rf_ra1   = rt;
        rf_ra2   = rt2;
        rf_rab   = rn;
        rf_wa1   = rt;
        rf_wa2   = rt2;
        rf_we    = res_we;
        flags_we = res_we;
    end
endmodule

// File: rtl/qos_chk.sv
// Protocol and outcome checker for qw_orset_unit, attached by bind.
// Assumes: the memory side answers a request only after accepting it.
module qos_chk #(
    parameter int XLEN = 64,
    localparam int QW  = 2 * XLEN
) (
    input logic            clk,
    input logic            rst_n,
    input logic            done,
    input logic            undef,
    input logic            nop,
    input logic            align_fault,
    input logic            rf_we,
    input logic            flags_we,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [1:0]      mem_req_op,
    input logic [XLEN-1:0] mem_req_addr,
    input logic [QW-1:0]   mem_req_wdata,
    input logic            mem_rsp_valid,
    input logic [QW-1:0]   mem_rsp_rdata,
    input logic            mem_rsp_pass
);
    logic          rd_out;
    logic          rd_pass_q;
    logic [QW-1:0] rd_data_q;

    // Track the result of the last locked read seen on the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_out <= 1'b0; rd_pass_q <= 1'b0; rd_data_q <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready && mem_req_op == 2'd0) rd_out <= 1'b1;
            else if (mem_rsp_valid) rd_out <= 1'b0;
            if (mem_rsp_valid && rd_out) begin
                rd_pass_q <= mem_rsp_pass;
                rd_data_q <= mem_rsp_rdata;
            end
        end
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_we_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || flags_we) |-> (done && rf_we && flags_we && !undef && !nop && !align_fault));
    p_outcome_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (undef || nop || align_fault) |-> (done && $onehot0({undef, nop, align_fault})));
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_op) && $stable(mem_req_addr) && $stable(mem_req_wdata)));
    p_write_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_op == 2'd1) |->
            (rd_pass_q && ((mem_req_wdata & rd_data_q) == rd_data_q)));
    p_unlock_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_op == 2'd2) |-> !rd_pass_q);
endmodule

bind qw_orset_unit qos_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .undef(undef), .nop(nop),
    .align_fault(align_fault), .rf_we(rf_we), .flags_we(flags_we),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_pass(mem_rsp_pass)
);

// File: tb/qw_orset_unit_tb.sv
module qw_orset_unit_tb;
    localparam int XLEN = 64;
    localparam int QW   = 128;

    typedef struct packed {
        logic       a, r, be, pass;
        logic [4:0] rt, rt2, rn;
        logic [1:0] ovl;
        logic [3:0] nz;
        logic [7:0] sp_lo;
        logic [1:0] exp_k;   // 0 exec, 1 undef, 2 nop, 3 fault
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 5'd1,  5'd2,  5'd3,  2'd1, 4'b0100, 8'h00, 2'd0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 5'd5,  5'd6,  5'd31, 2'd1, 4'b1010, 8'h00, 2'd0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 5'd7,  5'd8,  5'd9,  2'd1, 4'b0001, 8'h00, 2'd0},
        '{1'b0, 1'b1, 1'b1, 1'b0, 5'd10, 5'd11, 5'd31, 2'd1, 4'b0110, 8'h30, 2'd0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 5'd31, 5'd2,  5'd3,  2'd1, 4'b0000, 8'h00, 2'd1},
        '{1'b1, 1'b0, 1'b1, 1'b1, 5'd4,  5'd31, 5'd3,  2'd1, 4'b0000, 8'h00, 2'd1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 5'd4,  5'd4,  5'd3,  2'd2, 4'b0000, 8'h00, 2'd2},
        '{1'b0, 1'b0, 1'b0, 1'b1, 5'd12, 5'd13, 5'd31, 2'd1, 4'b0000, 8'h08, 2'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic feat_en = 1'b1, big_endian = 1'b0, start = 1'b0;
    logic [1:0] ovl_mode = 2'd1;
    logic [31:0] instr = '0;
    logic busy;
    logic [4:0] rf_ra1, rf_ra2, rf_rab, rf_wa1, rf_wa2;
    logic [XLEN-1:0] rf_rd1, rf_rd2, rf_rdb, rf_wd1, rf_wd2, mem_req_addr;
    logic [XLEN-1:0] sp = 64'h0000_0000_0000_1000;
    logic mem_req_valid, mem_req_ready = 1'b1;
    logic [1:0] mem_req_op;
    logic [QW-1:0] mem_req_wdata, mem_rsp_rdata = '0;
    logic mem_req_acq, mem_req_rel, mem_req_tagchk;
    logic mem_rsp_valid = 1'b0, mem_rsp_pass = 1'b0;
    logic [3:0] mem_rsp_nzcv = '0, flags;
    logic done, undef, nop, align_fault, rf_we, flags_we;

    int errors = 0, checks = 0, cyc = 0;
    logic [63:0] xr [32];
    logic [QW-1:0] mem_word;
    logic pend = 1'b0, stall = 1'b0, tb_pass = 1'b0;
    logic [3:0] tb_nz = '0;
    int n_rd, n_wr, n_ul, hold_err;
    logic rd_acq, rd_rel, rd_tag, prev_stall;
    logic [XLEN-1:0] rd_addr;

    always #10 clk = ~clk;

    qw_orset_unit u_dut (.*);

    assign rf_rd1 = xr[rf_ra1];
    assign rf_rd2 = xr[rf_ra2];
    assign rf_rdb = xr[rf_rab];

    initial for (int i = 0; i < 32; i++)
        xr[i] = {32'hA5A5_0000 | 32'(i), 32'h0F0F_0300 ^ (32'(i) << 12)};

    // Memory model, acting away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
        if (prev_stall && !mem_req_valid) hold_err++;
        mem_rsp_valid = pend;
        pend = 1'b0;
        mem_req_ready = stall ? (cyc % 3 == 0) : 1'b1;
        prev_stall = mem_req_valid && !mem_req_ready;
        if (mem_req_valid && mem_req_ready) begin
            pend = 1'b1;
            case (mem_req_op)
                2'd0: begin
                    n_rd++; mem_rsp_rdata = mem_word; mem_rsp_pass = tb_pass;
                    mem_rsp_nzcv = tb_nz; rd_addr = mem_req_addr;
                    rd_acq = mem_req_acq; rd_rel = mem_req_rel; rd_tag = mem_req_tagchk;
                end
                2'd1: begin n_wr++; mem_word = mem_req_wdata; end
                default: n_ul++;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [QW-1:0] act, input logic [QW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic a, input logic r, input logic [4:0] rt2,
                                       input logic [4:0] rn, input logic [4:0] rt);
        return {8'h19, a, r, 1'b1, rt2, 6'b101100, rn, rt};
    endfunction

    // Issue one instruction and wait at a falling edge for done.
    task automatic run(input logic [31:0] iw);
        int w = 0;
        n_rd = 0; n_wr = 0; n_ul = 0; hold_err = 0;
        @(negedge clk); instr = iw; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && w < 300) begin @(negedge clk); w++; end
        chk(done == 1'b1, "R10 done seen", QW'(done), 1);
    endtask

    task automatic check_exec(input logic [4:0] rt, input logic [4:0] rt2, input logic [4:0] rn,
                              input logic a, input logic r, input logic be, input logic pass,
                              input logic [3:0] nz, input logic [QW-1:0] m0, input bit unk);
        logic [QW-1:0] opnd, mexp, ret;
        logic [63:0] e1, e2;
        logic [63:0] eaddr;
        opnd  = be ? {xr[rt], xr[rt2]} : {xr[rt2], xr[rt]};
        mexp  = pass ? (m0 | opnd) : m0;
        ret   = unk ? '0 : m0;
        e1    = be ? ret[127:64] : ret[63:0];
        e2    = be ? ret[63:0] : ret[127:64];
        eaddr = (rn == 5'd31) ? sp : xr[rn];
        chk(rf_we && flags_we && !undef && !nop && !align_fault, "R10 write enables", QW'({rf_we, flags_we}), 3);
        chk(n_rd == 1, "R7 one locked read", QW'(n_rd), 1);
        chk(pass ? (n_wr == 1 && n_ul == 0) : (n_wr == 0 && n_ul == 1), "R7 write or unlock",
            QW'({n_wr[3:0], n_ul[3:0]}), pass ? 128'h10 : 128'h01);
        chk(mem_word == mexp, "R6 R7 memory after OR", mem_word, mexp);
        chk(rf_wd1 == e1 && rf_wd2 == e2, "R8 R4 returned halves", {rf_wd1, rf_wd2}, {e1, e2});
        chk(rf_wa1 == rt && rf_wa2 == rt2, "R8 write indices", QW'({rf_wa1, rf_wa2}), QW'({rt, rt2}));
        chk(flags == nz, "R9 flags", QW'(flags), QW'(nz));
        chk(rd_addr == eaddr, "R5 address", QW'(rd_addr), QW'(eaddr));
        chk(rd_acq == a && rd_rel == r && rd_tag == (rn != 5'd31), "R1 attributes",
            QW'({rd_acq, rd_rel, rd_tag}), QW'({a, r, rn != 5'd31}));
        @(negedge clk);
        chk(!done && !rf_we, "R10 single-cycle done", QW'(done), 0);
    endtask

    task automatic check_kind(input logic [1:0] k, input string tag);
        chk(n_rd == 0 && n_wr == 0 && n_ul == 0 && !mem_req_valid, {tag, " no memory access"}, QW'(n_rd), 0);
        chk(undef == (k == 2'd1) && nop == (k == 2'd2) && align_fault == (k == 2'd3) && !rf_we && !flags_we,
            {tag, " outcome"}, QW'({undef, nop, align_fault, rf_we}),
            QW'({k == 2'd1, k == 2'd2, k == 2'd3, 1'b0}));
    endtask

    initial begin
        logic [QW-1:0] m0;
        mem_word = '0; prev_stall = 1'b0;
        repeat (3) @(negedge clk);
        // Reset state.
        chk(!done && !busy && !mem_req_valid && !rf_we && !flags_we, "R10 reset state",
            QW'({done, busy, mem_req_valid, rf_we}), 0);
        rst_n = 1'b1;

        // Vector table.
        for (int i = 0; i < 8; i++) begin
            m0 = {64'hF0F0_0000_1234_0000 ^ 64'(i), 64'h0000_00FF_0000_5555 ^ (64'(i) << 40)};
            mem_word = m0; big_endian = VECS[i].be; ovl_mode = VECS[i].ovl;
            tb_pass = VECS[i].pass; tb_nz = VECS[i].nz;
            sp = 64'h0000_0000_0000_1000 | 64'(VECS[i].sp_lo);
            run(mk(VECS[i].a, VECS[i].r, VECS[i].rt2, VECS[i].rn, VECS[i].rt));
            if (VECS[i].exp_k == 2'd0)
                check_exec(VECS[i].rt, VECS[i].rt2, VECS[i].rn, VECS[i].a, VECS[i].r,
                           VECS[i].be, VECS[i].pass, VECS[i].nz, m0, 1'b0);
            else
                check_kind(VECS[i].exp_k, VECS[i].exp_k == 2'd3 ? "R5 misaligned sp" :
                           VECS[i].exp_k == 2'd2 ? "R4 overlap nop" : "R3 reserved register");
            repeat (2) @(negedge clk);
        end

        // R4: overlap mode 0 runs with zero return data.
        m0 = 128'h0123_4567_89AB_CDEF_0000_1111_2222_3333;
        mem_word = m0; ovl_mode = 2'd0; big_endian = 1'b1; tb_pass = 1'b1; tb_nz = 4'b1001;
        run(mk(1'b0, 1'b0, 5'd6, 5'd2, 5'd6));
        check_exec(5'd6, 5'd6, 5'd2, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1001, m0, 1'b1);
        // R4: modes 1 and 3 are undefined.
        ovl_mode = 2'd1; run(mk(1'b0, 1'b0, 5'd6, 5'd2, 5'd6)); check_kind(2'd1, "R4 overlap mode1");
        ovl_mode = 2'd3; run(mk(1'b0, 1'b0, 5'd6, 5'd2, 5'd6)); check_kind(2'd1, "R4 overlap mode3");
        ovl_mode = 2'd1;
        // R2: feature disabled, then a wrong fixed bit.
        feat_en = 1'b0; run(mk(1'b0, 1'b0, 5'd2, 5'd3, 5'd1)); check_kind(2'd1, "R2 feature off");
        feat_en = 1'b1; run(mk(1'b0, 1'b0, 5'd2, 5'd3, 5'd1) ^ 32'h0000_0400);
        check_kind(2'd1, "R2 bad opcode bit");
        // R11: stalled ready, result unchanged.
        m0 = 128'h8000_0000_0000_0001_0000_0000_F000_000F;
        mem_word = m0; big_endian = 1'b0; tb_pass = 1'b1; tb_nz = 4'b0011; stall = 1'b1;
        run(mk(1'b1, 1'b1, 5'd14, 5'd15, 5'd16));
        stall = 1'b0;
        chk(hold_err == 0, "R11 request held under stall", QW'(hold_err), 0);
        check_exec(5'd16, 5'd14, 5'd15, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0011, m0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule